// File: doc/BRIEF.md
# TDM Stereo Serial Output Formatter

This block drives a time-division-multiplexed audio line as the timing master. It runs from the bit clock and produces a one-clock frame marker, a serial data bit and a drive-enable. Several devices can share one line. A frame is split into sub-frames, and each sub-frame holds a left slot followed by a right slot. Each device fills only the sub-frame picked by its own select input and releases the line for the rest of the frame. Outside the block, the enable controls a tri-state buffer.

The speed-mode input sets how many sub-frames a frame holds: four, two or one. Samples arrive as a left/right pair with a valid strobe. The pair strobed most recently is latched at the start of each frame and goes out during that frame. The mode and select inputs are also latched at the start of each frame, so a frame already in progress keeps its length and its window.

Top module: `tdm_fmt_top`

## Requirements
- R1: The frame length in bit clocks is 256 when `spd_mode` is 2'b00 (normal), 128 when it is 2'b01 (double) and 64 when it is 2'b10 or 2'b11 (quad). `frm_clk` repeats with exactly that period.
- R2: `frm_clk` is high for exactly one bit clock, which is the first bit of each frame. The first pulse comes in the first bit clock after reset is released.
- R3: A frame carries the pair strobed by the last `smp_valid` at or before that frame's first bit clock. This includes a strobe in the last cycle of the previous frame. A strobe later in the frame does not change the bits of that frame.
- R4: Within a 64-bit sub-frame, bits 0–31 form the left slot and bits 32–63 the right slot. Each slot sends its 24-bit sample MSB first in slot bits 0–23, followed by 8 zero bits.
- R5: In normal mode, `sdata_oe` is high only in frame bits 64*s to 64*s+63, where s is `sub_sel`.
- R6: In double mode, only `sub_sel[0]` is used. The window is frame bits 0–63 when it is 0 and bits 64–127 when it is 1.
- R7: In quad mode, `sub_sel` is ignored and `sdata_oe` is high for the whole frame.
- R8: `sdata` is low whenever `sdata_oe` is low.
- R9: A change on `spd_mode` or `sub_sel` in the middle of a frame takes effect only at the next frame start.
- R10: While `rst` is high, `frm_clk`, `sdata` and `sdata_oe` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst | input | 1 | Synchronous active-high reset |
| spd_mode | input | 2 | Speed mode: 00 normal, 01 double, 1x quad |
| sub_sel | input | 2 | Sub-frame position of this device |
| smp_valid | input | 1 | Strobe that marks a new sample pair |
| smp_left | input | 24 | Left sample |
| smp_right | input | 24 | Right sample |
| frm_clk | output | 1 | Frame start marker, one bit clock wide |
| sdata | output | 1 | Serial data bit |
| sdata_oe | output | 1 | Line drive enable |

## Verification
The properties assume that `spd_mode` and `sub_sel` may change at any time but are sampled only at frame boundaries. This lets them assume that the mode stays constant between markers. They also assume that at least one bit clock passes between frame markers, which holds because the shortest frame is 64 clocks. The stimulus changes inputs only on the falling edge of the bit clock. It holds `smp_valid` for a single cycle and moves the mode or select mid-frame only in the scenario that targets R9.

// File: rtl/tdm_fmt_pkg.sv
package tdm_fmt_pkg;

    localparam int SLOT_W    = 32;
    localparam int SAMPLE_W  = 24;
    localparam int SUB_MAX   = 4;
    localparam int PAIR_BITS = 2 * SLOT_W;
    localparam int FRAME_MAX = SUB_MAX * PAIR_BITS;
    localparam int CNT_W     = $clog2(FRAME_MAX);
    localparam int POS_W     = $clog2(PAIR_BITS);
    localparam int BIT_W     = $clog2(SLOT_W);
    localparam int SEL_W     = $clog2(SUB_MAX);

    typedef enum logic [1:0] {
        SPD_NORMAL   = 2'b00,
        SPD_DOUBLE   = 2'b01,
        SPD_QUAD     = 2'b10,
        SPD_QUAD_ALT = 2'b11
    } spd_mode_e;

    typedef struct packed {
        logic [SAMPLE_W-1:0] left;
        logic [SAMPLE_W-1:0] right;
    } pair_t;

    typedef struct packed {
        spd_mode_e          mode;
        logic [SEL_W-1:0]   sel;
    } frame_cfg_t;

    // Last bit index of a frame for a given mode.
    function automatic logic [CNT_W-1:0] frame_last(spd_mode_e m);
        case (m)
            SPD_NORMAL: return CNT_W'(FRAME_MAX - 1);
            SPD_DOUBLE: return CNT_W'(FRAME_MAX / 2 - 1);
            default:    return CNT_W'(PAIR_BITS - 1);
        endcase
    endfunction

    // True while the frame position lies in this device's sub-frame.
    function automatic logic sub_hit(spd_mode_e m, logic [CNT_W-1:0] c,
                                     logic [SEL_W-1:0] s);
        case (m)
            SPD_NORMAL: return c[CNT_W-1:POS_W] == s;
            SPD_DOUBLE: return c[POS_W] == s[0];
            default:    return 1'b1;
        endcase
    endfunction

endpackage

// File: rtl/tdm_frame_timer.sv
module tdm_frame_timer
    import tdm_fmt_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  spd_mode_e            mode_in,
    input  logic [SEL_W-1:0]     sel_in,
    output logic [CNT_W-1:0]     cnt,
    output logic                 wrap,
    output frame_cfg_t           cfg
);

    assign wrap = (cnt == frame_last(cfg.mode));

    always_ff @(posedge clk) begin
        if (rst) begin
            // Parked on the last bit so the first edge after reset starts a frame
            cnt      <= CNT_W'(FRAME_MAX - 1);
            cfg.mode <= SPD_NORMAL;
            cfg.sel  <= '0;
        end else if (wrap) begin
            cnt      <= '0;
            cfg.mode <= mode_in;
            cfg.sel  <= sel_in;
        end else begin
            cnt      <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/tdm_pair_latch.sv
module tdm_pair_latch
    import tdm_fmt_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   smp_valid,
    input  pair_t  smp_in,
    input  logic   load,
    output pair_t  act
);

    pair_t hold;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold <= '0;
            act  <= '0;
        end else begin
            if (smp_valid)
                hold <= smp_in;
            if (load)
                act <= smp_valid ? smp_in : hold;
        end
    end

endmodule

// File: rtl/tdm_slot_serializer.sv
module tdm_slot_serializer
    import tdm_fmt_pkg::*;
(
    input  logic [CNT_W-1:0] cnt,
    input  frame_cfg_t       cfg,
    input  pair_t            act,
    output logic             lrck,
    output logic             sdata,
    output logic             oe
);

    localparam int PAD_W = SLOT_W - SAMPLE_W;

    logic [POS_W-1:0]    pos;
    logic [BIT_W-1:0]    bidx;
    logic [BIT_W-1:0]    ridx;
    logic [SAMPLE_W-1:0] word;
    logic [SLOT_W-1:0]   slot_vec;

    assign pos  = cnt[POS_W-1:0];
    assign bidx = pos[BIT_W-1:0];
    assign ridx = BIT_W'(SLOT_W - 1) - bidx;
    assign word = pos[POS_W-1] ? act.right : act.left;

    generate
        if (PAD_W > 0) begin : g_pad
            assign slot_vec = {word, {PAD_W{1'b0}}};
        end else begin : g_full
            assign slot_vec = word[SAMPLE_W-1 -: SLOT_W];
        end
    endgenerate

    assign oe    = sub_hit(cfg.mode, cnt, cfg.sel);
    assign sdata = oe & slot_vec[ridx];
    assign lrck  = (cnt == '0);

endmodule

// File: rtl/tdm_fmt_top.sv
module tdm_fmt_top
    import tdm_fmt_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [1:0]  spd_mode,
    input  logic [1:0]  sub_sel,
    input  logic        smp_valid,
    input  logic [23:0] smp_left,
    input  logic [23:0] smp_right,
    output logic        frm_clk,
    output logic        sdata,
    output logic        sdata_oe
);

    logic [CNT_W-1:0] bit_cnt;
    logic             frame_wrap;
    frame_cfg_t       cfg;
    pair_t            in_pair;
    pair_t            act_pair;
    logic [1:0]       cur_mode;

    assign in_pair.left  = smp_left;
    assign in_pair.right = smp_right;
    assign cur_mode      = cfg.mode;

    tdm_frame_timer u_timer (
        .clk     (clk),
        .rst     (rst),
        .mode_in (spd_mode_e'(spd_mode)),
        .sel_in  (sub_sel),
        .cnt     (bit_cnt),
        .wrap    (frame_wrap),
        .cfg     (cfg)
    );

    tdm_pair_latch u_latch (
        .clk       (clk),
        .rst       (rst),
        .smp_valid (smp_valid),
        .smp_in    (in_pair),
        .load      (frame_wrap),
        .act       (act_pair)
    );

    tdm_slot_serializer u_ser (
        .cnt   (bit_cnt),
        .cfg   (cfg),
        .act   (act_pair),
        .lrck  (frm_clk),
        .sdata (sdata),
        .oe    (sdata_oe)
    );

endmodule

// File: rtl/tdm_fmt_chk.sv
module tdm_fmt_chk
    import tdm_fmt_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             frm_clk,
    input logic             sdata,
    input logic             sdata_oe,
    input logic [CNT_W-1:0] cnt,
    input logic [1:0]       mode
);

    p_lrck_single_r2: assert property (@(posedge clk) disable iff (rst)
        frm_clk |=> !frm_clk);

    p_quiet_low_r8: assert property (@(posedge clk) disable iff (rst)
        !sdata_oe |-> !sdata);

    p_quad_oe_r7: assert property (@(posedge clk) disable iff (rst)
        mode[1] |-> sdata_oe);

    p_pad_zero_r4: assert property (@(posedge clk) disable iff (rst)
        (cnt[BIT_W-1:0] >= BIT_W'(SAMPLE_W)) |-> !sdata);

    p_oe_edge_r5: assert property (@(posedge clk) disable iff (rst)
        ($rose(sdata_oe) || $fell(sdata_oe)) |-> (cnt[POS_W-1:0] == '0));

    p_mode_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !frm_clk |-> $stable(mode));

endmodule

bind tdm_fmt_top tdm_fmt_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .frm_clk  (frm_clk),
    .sdata    (sdata),
    .sdata_oe (sdata_oe),
    .cnt      (bit_cnt),
    .mode     (cur_mode)
);

// File: tb/tdm_fmt_top_tb.sv
module tdm_fmt_top_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  spd_mode = 2'b00;
    logic [1:0]  sub_sel = 2'b00;
    logic        smp_valid = 1'b0;
    logic [23:0] smp_left = '0;
    logic [23:0] smp_right = '0;
    logic        frm_clk, sdata, sdata_oe;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    tdm_fmt_top u_dut (
        .clk(clk), .rst(rst), .spd_mode(spd_mode), .sub_sel(sub_sel),
        .smp_valid(smp_valid), .smp_left(smp_left), .smp_right(smp_right),
        .frm_clk(frm_clk), .sdata(sdata), .sdata_oe(sdata_oe)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int flen(input logic [1:0] m);
        return (m == 2'b00) ? 256 : (m == 2'b01) ? 128 : 64;
    endfunction

    // Expected {oe, data} at frame bit c, built from R4-R7
    function automatic logic [1:0] exp_bits(input logic [1:0] m, input logic [1:0] s,
                                            input logic [23:0] l, input logic [23:0] r,
                                            input int c);
        int sub = c / 64;
        int p   = c % 64;
        int b   = p % 32;
        logic hit;
        logic [23:0] w;
        hit = (m[1]) ? 1'b1 : (m == 2'b01) ? (sub == int'(s[0])) : (sub == int'(s));
        w   = (p < 32) ? l : r;
        return {hit, (hit && b < 24) ? w[23-b] : 1'b0};
    endfunction

    task automatic wait_lrck();
        int guard = 0;
        do begin
            @(negedge clk);
            guard++;
        end while (!frm_clk && guard < 400);
    endtask

    task automatic send_pair(input logic [23:0] l, input logic [23:0] r);
        @(negedge clk);
        smp_valid = 1'b1; smp_left = l; smp_right = r;
        @(negedge clk);
        smp_valid = 1'b0;
    endtask

    // Called at the negedge where frm_clk is high; ends at the next frame start.
    task automatic frame_chk(input logic [1:0] m, input logic [1:0] s,
                             input logic [23:0] l, input logic [23:0] r,
                             input string tag,
                             input int mid_at, input logic [23:0] ml, input logic [23:0] mr,
                             input int chg_at, input logic [1:0] cm, input logic [1:0] cs);
        int len = flen(m);
        int errs = 0;
        int first_c = -1;
        int lr_bad = 0;
        logic [1:0] e;
        logic [1:0] a_first = 2'b00;
        logic [1:0] e_first = 2'b00;
        for (int c = 0; c < len; c++) begin
            e = exp_bits(m, s, l, r, c);
            if ({sdata_oe, sdata} !== e) begin
                errs++;
                if (first_c < 0) begin first_c = c; a_first = {sdata_oe, sdata}; e_first = e; end
            end
            if (c > 0 && frm_clk) lr_bad++;
            smp_valid = (c == mid_at);
            if (c == mid_at) begin smp_left = ml; smp_right = mr; end
            if (c == chg_at) begin spd_mode = cm; sub_sel = cs; end
            @(negedge clk);
        end
        smp_valid = 1'b0;
        if (errs != 0)
            $display("  %s: first mismatch at frame bit %0d", tag, first_c);
        check(errs == 0, {tag, " frame bits {oe,data}"}, int'(a_first), int'(e_first));
        check(lr_bad == 0, "R2 single marker per frame", lr_bad, 0);
        check(frm_clk === 1'b1, "R1 frame length", int'(frm_clk), 1);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (4) @(negedge clk);
        // R10
        check({frm_clk, sdata, sdata_oe} === 3'b000, "R10 outputs low in reset",
              int'({frm_clk, sdata, sdata_oe}), 0);
        rst = 1'b0;
        @(negedge clk);
        check(frm_clk === 1'b1, "R2 first marker after reset", int'(frm_clk), 1);
    endtask

    task automatic t_normal();
        for (int s = 0; s < 4; s++) begin
            spd_mode = 2'b00; sub_sel = 2'(s);
            send_pair(24'hA50000 + 24'(s), 24'h0F0F00 ^ 24'(s * 77));
            wait_lrck();
            frame_chk(2'b00, 2'(s), 24'hA50000 + 24'(s), 24'h0F0F00 ^ 24'(s * 77),
                      "R4 R5 normal", -1, 0, 0, -1, 0, 0);
        end
    endtask

    task automatic t_double();
        for (int s = 0; s < 4; s++) begin
            spd_mode = 2'b01; sub_sel = 2'(s);
            send_pair(24'h800001 ^ 24'(s), 24'h7FFFFE);
            wait_lrck();
            frame_chk(2'b01, 2'(s), 24'h800001 ^ 24'(s), 24'h7FFFFE,
                      "R6 double", -1, 0, 0, -1, 0, 0);
        end
    endtask

    task automatic t_quad();
        for (int s = 0; s < 2; s++) begin
            spd_mode = 2'b10 + 2'(s); sub_sel = 2'(3 - s);
            send_pair(24'hFFFFFF, 24'h123456);
            wait_lrck();
            frame_chk(2'b10 + 2'(s), 2'(3 - s), 24'hFFFFFF, 24'h123456,
                      "R7 quad", -1, 0, 0, -1, 0, 0);
        end
    endtask

    task automatic t_latch();
        spd_mode = 2'b00; sub_sel = 2'b00;
        send_pair(24'h111111, 24'h222222);
        wait_lrck();
        // R3: a strobe mid-frame must not disturb the frame in progress
        frame_chk(2'b00, 2'b00, 24'h111111, 24'h222222, "R3 mid-frame strobe",
                  5, 24'h333333, 24'h444444, -1, 0, 0);
        // R3: a strobe in the last cycle is taken by the next frame
        frame_chk(2'b00, 2'b00, 24'h333333, 24'h444444, "R3 pending pair",
                  255, 24'h5A5A5A, 24'hC3C3C3, -1, 0, 0);
        frame_chk(2'b00, 2'b00, 24'h5A5A5A, 24'hC3C3C3, "R3 last-cycle strobe",
                  -1, 0, 0, -1, 0, 0);
    endtask

    task automatic t_switch();
        spd_mode = 2'b00; sub_sel = 2'b01;
        wait_lrck();
        // R9: change mid-frame, current frame keeps normal length and window
        frame_chk(2'b00, 2'b01, 24'h5A5A5A, 24'hC3C3C3, "R9 held config",
                  -1, 0, 0, 10, 2'b01, 2'b11);
        frame_chk(2'b01, 2'b11, 24'h5A5A5A, 24'hC3C3C3, "R9 new config",
                  -1, 0, 0, 3, 2'b10, 2'b00);
        frame_chk(2'b10, 2'b00, 24'h5A5A5A, 24'hC3C3C3, "R9 R1 quad after switch",
                  -1, 0, 0, -1, 0, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_normal();
        t_double();
        t_quad();
        t_latch();
        t_switch();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule